// File: doc/BRIEF.md
# Two-Output Clock Divider Chain

This block turns one master clock into two slower rates that stay locked to it. The first branch is a power-of-two prescaler whose rate feeds the reference output's source selection further down the chip. The second branch is another power-of-two prescaler. Its result either goes straight to the main output or passes through a programmable integer divider first. No new clock net is created. Every stage is a counter in the master clock domain. Each branch presents a one-cycle enable strobe that marks the end of its output period, plus a square-wave level for logic that needs a waveform.

The settings arrive as field values from a register file elsewhere: a 2-bit prescaler code per branch, a 10-bit divider value and a bypass bit. A stage does not switch to a new setting in the middle of a period. It adopts the new value at its own next terminal count, so every period that has started runs to full length. Output gating, source muxing and power control sit outside this block.

Top module: `clkdiv_chain`

## Requirements
- R1: While reset is asserted, p0Tick is 1, p0Lvl is 1, out1Tick is 0 and out1Lvl is 1. This matches both prescalers dividing by 1 and a divider value of 0, which divides by 2.
- R2: The p0Code input selects the first prescaler's ratio, with 0 giving 1, 1 giving 2, 2 giving 4 and 3 giving 8. p0Tick is high for one master cycle, once per that many cycles.
- R3: The p1Code input selects the second prescaler's ratio with the same encoding as R2 (0:1, 1:2, 2:4, 3:8).
- R4: With bypassN at 0, the out1Tick period is the second prescaler's ratio times (nValue + 2). nValue 0 gives a factor of 2 and nValue 1023 gives a factor of 1025.
- R5: With bypassN at 1, out1Tick follows the second prescaler alone, and no value of nValue changes its period.
- R6: For a prescaler ratio R of 2 or more, the branch level is high for the first R/2 master cycles of each period. At ratio 1 the level stays high.
- R7: With bypassN at 0, out1Lvl is high for the first floor((nValue+2)/2) prescaler periods of each output period and low for the rest. With bypassN at 1, out1Lvl equals the second prescaler's level.
- R8: A change to a code, to nValue or to bypassN takes effect only after the current period of that stage ends. The period in progress completes at its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| p0Code | input | 2 | Ratio code of the first prescaler |
| p1Code | input | 2 | Ratio code of the second prescaler |
| nValue | input | 10 | Divider setting, divisor is value plus 2 |
| bypassN | input | 1 | 1 routes the second prescaler straight to the main output |
| p0Tick | output | 1 | End-of-period strobe of the first branch |
| p0Lvl | output | 1 | Square-wave level of the first branch |
| out1Tick | output | 1 | End-of-period strobe of the main output |
| out1Lvl | output | 1 | Square-wave level of the main output |

## Verification
The in-line properties check the following on every cycle:
- Each counter stays below the ratio it is running.
- Each counter either steps by one or wraps to zero after its strobe.
- Active settings never move except at a terminal count.
- The main level is low at the divider's wrap.

Only the bench scenarios can show the following:
- The exact period for each prescaler code and for several divider values, including both ends of the range.
- That the divider value is inert under bypass.
- The measured high time for odd divisors.
- That a setting changed partway through a period lets that period finish at its old length.

// File: rtl/clkdiv_chain_pkg.sv
package clkdiv_chain_pkg;

  // Strobes sent from the control half to the counter half each cycle.
  typedef struct packed {
    logic [1:0] preWrap;  // prescaler i reaches its last count this cycle
    logic       nStep;    // divider advances by one
    logic       nWrap;    // divider (or bypassed chain) ends its period
  } chainStb_t;

endpackage

// File: rtl/clkdiv_chain_dp.sv
module clkdiv_chain_dp
  import clkdiv_chain_pkg::*;
#(
  parameter  int CODE_W    = 2,
  parameter  int N_W       = 10,
  localparam int PRE_CNT_W = (1 << CODE_W) - 1,
  localparam int NCNT_W    = N_W + 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  chainStb_t                        stb,
  output logic [1:0][PRE_CNT_W-1:0]        preCnt,
  output logic [NCNT_W-1:0]                nCnt
);

  localparam logic [PRE_CNT_W-1:0] PRE_ONE = {{(PRE_CNT_W-1){1'b0}}, 1'b1};
  localparam logic [NCNT_W-1:0]    N_ONE   = {{(NCNT_W-1){1'b0}}, 1'b1};

  // Up-counters: control decides when each one wraps.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      nCnt   <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (stb.preWrap[i]) preCnt[i] <= '0;
        else                preCnt[i] <= preCnt[i] + PRE_ONE;
      end
      if (stb.nWrap)      nCnt <= '0;
      else if (stb.nStep) nCnt <= nCnt + N_ONE;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_preChk
    // R2: a wrap strobe returns the prescaler to zero
    p_pre_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
      stb.preWrap[g] |=> preCnt[g] == '0);
    // R6: without a wrap the prescaler advances by exactly one
    p_pre_step_r6: assert property (@(posedge clk) disable iff (!rstN)
      !stb.preWrap[g] |=> preCnt[g] == $past(preCnt[g]) + PRE_ONE);
  end

  // R4: the divider advances only on its step strobe
  p_n_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.nStep |=> nCnt == $past(nCnt) + N_ONE);
  // R8: with no strobe the divider count holds
  p_n_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.nStep && !stb.nWrap) |=> $stable(nCnt));

endmodule

// File: rtl/clkdiv_chain_ctrl.sv
module clkdiv_chain_ctrl
  import clkdiv_chain_pkg::*;
#(
  parameter  int CODE_W    = 2,
  parameter  int N_W       = 10,
  parameter  int N_OFFSET  = 2,
  localparam int PRE_CNT_W = (1 << CODE_W) - 1,
  localparam int NCNT_W    = N_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [CODE_W-1:0]         p0Code,
  input  logic [CODE_W-1:0]         p1Code,
  input  logic [N_W-1:0]            nValue,
  input  logic                      bypassN,
  input  logic [1:0][PRE_CNT_W-1:0] preCnt,
  input  logic [NCNT_W-1:0]         nCnt,
  output chainStb_t                 stb,
  output logic                      p0Tick,
  output logic                      p0Lvl,
  output logic                      out1Tick,
  output logic                      out1Lvl
);

  localparam logic [PRE_CNT_W:0]  RATIO_ONE = {{PRE_CNT_W{1'b0}}, 1'b1};
  localparam logic [NCNT_W-1:0]   N_ONE     = {{(NCNT_W-1){1'b0}}, 1'b1};
  localparam logic [NCNT_W-1:0]   N_BASE    = NCNT_W'(N_OFFSET);

  logic [CODE_W-1:0]  actCode  [2];
  logic [CODE_W-1:0]  newCode  [2];
  logic [PRE_CNT_W:0] preRatio [2];
  logic [1:0]         preTerm;
  logic [1:0]         preLvl;

  assign newCode[0] = p0Code;
  assign newCode[1] = p1Code;

  // One prescaler control slice per branch.
  for (genvar g = 0; g < 2; g++) begin : g_pre
    assign preRatio[g] = RATIO_ONE << actCode[g];
    assign preTerm[g]  = ({1'b0, preCnt[g]} == preRatio[g] - RATIO_ONE);
    assign preLvl[g]   = (actCode[g] == '0) ? 1'b1
                       : ({1'b0, preCnt[g]} < (preRatio[g] >> 1));

    // Adopt a new code only at the end of the running period.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           actCode[g] <= '0;
      else if (preTerm[g]) actCode[g] <= newCode[g];
    end

    // R8: active code cannot move mid-period
    p_code_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      !preTerm[g] |=> $stable(actCode[g]));
    // R2: counter never reaches the ratio it divides by
    p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
      {1'b0, preCnt[g]} < preRatio[g]);
  end

  // Programmable divider control.
  logic [N_W-1:0]    actN;
  logic              actByp;
  logic [NCNT_W-1:0] nRatio;
  logic              nTerm;
  logic              chainWrap;

  assign nRatio    = {1'b0, actN} + N_BASE;
  assign nTerm     = (nCnt == nRatio - N_ONE);
  assign chainWrap = preTerm[1] & (actByp | nTerm);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actN   <= '0;
      actByp <= 1'b0;
    end else if (chainWrap) begin
      actN   <= nValue;
      actByp <= bypassN;
    end
  end

  always_comb begin
    stb.preWrap = preTerm;
    stb.nWrap   = chainWrap;
    stb.nStep   = preTerm[1] & ~actByp & ~nTerm;
  end

  assign p0Tick   = preTerm[0];
  assign p0Lvl    = preLvl[0];
  assign out1Tick = chainWrap;
  assign out1Lvl  = actByp ? preLvl[1] : (nCnt < (nRatio >> 1));

  // R8: divider setting and bypass only change at the chain's end of period
  p_n_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !out1Tick |=> ($stable(actN) && $stable(actByp)));
  // R4: divider count stays inside the active divisor
  p_n_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    nCnt < nRatio);
  // R7: the last divider period of each output period is in the low phase
  p_lvl_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (out1Tick && !actByp) |-> !out1Lvl);
  // R5: under bypass the divider count rests at zero after a wrap
  p_byp_rest_r5: assert property (@(posedge clk) disable iff (!rstN)
    (out1Tick && bypassN) |=> nCnt == '0);

endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
  import clkdiv_chain_pkg::*;
#(
  parameter int CODE_W   = 2,
  parameter int N_W      = 10,
  parameter int N_OFFSET = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] p0Code,
  input  logic [CODE_W-1:0] p1Code,
  input  logic [N_W-1:0]    nValue,
  input  logic              bypassN,
  output logic              p0Tick,
  output logic              p0Lvl,
  output logic              out1Tick,
  output logic              out1Lvl
);

  localparam int PRE_CNT_W = (1 << CODE_W) - 1;
  localparam int NCNT_W    = N_W + 1;

  chainStb_t                 stb;
  logic [1:0][PRE_CNT_W-1:0] preCnt;
  logic [NCNT_W-1:0]         nCnt;

  clkdiv_chain_ctrl #(
    .CODE_W(CODE_W), .N_W(N_W), .N_OFFSET(N_OFFSET)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .p0Code(p0Code), .p1Code(p1Code), .nValue(nValue), .bypassN(bypassN),
    .preCnt(preCnt), .nCnt(nCnt), .stb(stb),
    .p0Tick(p0Tick), .p0Lvl(p0Lvl), .out1Tick(out1Tick), .out1Lvl(out1Lvl)
  );

  clkdiv_chain_dp #(
    .CODE_W(CODE_W), .N_W(N_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .preCnt(preCnt), .nCnt(nCnt)
  );

endmodule

// File: tb/test_clkdiv_chain.sv
module test_clkdiv_chain;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] p0Code = '0;
  logic [1:0] p1Code = '0;
  logic [9:0] nValue = '0;
  logic       bypassN = 1'b0;
  logic       p0Tick, p0Lvl, out1Tick, out1Lvl;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  clkdiv_chain i_clkdiv_chain (
    .clk(clk), .rstN(rstN), .p0Code(p0Code), .p1Code(p1Code),
    .nValue(nValue), .bypassN(bypassN),
    .p0Tick(p0Tick), .p0Lvl(p0Lvl), .out1Tick(out1Tick), .out1Lvl(out1Lvl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: integer counts, settings adopted at period ends.
  int  mC0 = 0, mA0 = 0, mC1 = 0, mA1 = 0, mCn = 0, mAn = 0;
  bit  mByp = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      mC0 = 0; mA0 = 0; mC1 = 0; mA1 = 0; mCn = 0; mAn = 0; mByp = 0;
    end else if (!done) begin
      int r0, r1, rn;
      bit t0, t1, tn, l0, l1, eTick, eLvl;
      r0 = 1 << mA0;
      r1 = 1 << mA1;
      rn = mAn + 2;
      t0 = (mC0 == r0 - 1);
      t1 = (mC1 == r1 - 1);
      tn = (mCn == rn - 1);
      l0 = (r0 == 1) ? 1'b1 : (mC0 < r0 / 2);
      l1 = (r1 == 1) ? 1'b1 : (mC1 < r1 / 2);
      eTick = t1 && (mByp || tn);
      eLvl  = mByp ? l1 : (mCn < rn / 2);
      chk("R2", "p0Tick cycle", int'(p0Tick), int'(t0));
      chk("R6", "p0Lvl cycle", int'(p0Lvl), int'(l0));
      chk("R4", "out1Tick cycle", int'(out1Tick), int'(eTick));
      chk("R7", "out1Lvl cycle", int'(out1Lvl), int'(eLvl));
      // advance the model to the state after the coming rising edge
      if (t0) begin mC0 = 0; mA0 = int'(p0Code); end
      else mC0++;
      if (eTick) begin mCn = 0; mAn = int'(nValue); mByp = bypassN; end
      else if (t1) mCn++;
      if (t1) begin mC1 = 0; mA1 = int'(p1Code); end
      else mC1++;
    end
  end

  function automatic bit tickOf(input int sel);
    return (sel == 0) ? p0Tick : out1Tick;
  endfunction

  function automatic bit lvlOf(input int sel);
    return (sel == 0) ? p0Lvl : out1Lvl;
  endfunction

  task automatic waitTick(input int sel);
    do @(negedge clk); while (!tickOf(sel));
  endtask

  task automatic gapToTick(input int sel, output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tickOf(sel));
  endtask

  task automatic measPeriod(input int sel, input int exp, input string req, input string what);
    int gap;
    waitTick(sel);
    gapToTick(sel, gap);
    chk(req, what, gap, exp);
  endtask

  task automatic measHigh(input int sel, input int period, input int exp, input string req, input string what);
    int hi = 0;
    waitTick(sel);
    for (int k = 0; k < period; k++) begin
      @(negedge clk);
      if (lvlOf(sel)) hi++;
    end
    chk(req, what, hi, exp);
  endtask

  task automatic setCfg(input int c0, input int c1, input int nv, input bit byp);
    @(posedge clk); #1;
    p0Code = 2'(c0); p1Code = 2'(c1); nValue = 10'(nv); bypassN = byp;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "p0Tick reset", int'(p0Tick), 1);
    chk("R1", "p0Lvl reset", int'(p0Lvl), 1);
    chk("R1", "out1Tick reset", int'(out1Tick), 0);
    chk("R1", "out1Lvl reset", int'(out1Lvl), 1);
    @(posedge clk); #1 rstN = 1'b1;

    // R2: each first-prescaler code
    for (int c = 0; c < 4; c++) begin
      setCfg(c, 0, 0, 1'b0);
      waitTick(0);
      measPeriod(0, 1 << c, "R2", "p0 period");
    end
    // R6: level high time of the first branch
    setCfg(3, 0, 0, 1'b0); waitTick(0);
    measHigh(0, 8, 4, "R6", "p0 high cycles ratio 8");
    setCfg(2, 0, 0, 1'b0); waitTick(0);
    measHigh(0, 4, 2, "R6", "p0 high cycles ratio 4");

    // R3: each second-prescaler code, seen through the bypass path
    for (int c = 0; c < 4; c++) begin
      setCfg(0, c, 700, 1'b1);
      waitTick(1);
      measPeriod(1, 1 << c, "R3", "p1 period via bypass");
    end

    // R5: divider value has no effect under bypass
    setCfg(0, 1, 700, 1'b1); waitTick(1);
    measPeriod(1, 2, "R5", "bypass period nValue 700");
    setCfg(0, 1, 5, 1'b1); waitTick(1);
    measPeriod(1, 2, "R5", "bypass period nValue 5");
    measHigh(1, 2, 1, "R7", "bypass level follows p1");

    // R4: divider range and combination with the prescaler
    setCfg(0, 0, 0, 1'b0); waitTick(1);
    measPeriod(1, 2, "R4", "divide 2");
    setCfg(0, 0, 5, 1'b0); waitTick(1);
    measPeriod(1, 7, "R4", "divide 7");
    setCfg(0, 0, 1023, 1'b0); waitTick(1);
    measPeriod(1, 1025, "R4", "divide 1025");
    setCfg(0, 2, 3, 1'b0); waitTick(1);
    measPeriod(1, 20, "R3", "p1 ratio 4 times divider 5");

    // R7: high time with odd and even divisors
    setCfg(0, 1, 1, 1'b0); waitTick(1);
    measHigh(1, 6, 2, "R7", "divisor 3 p1 ratio 2");
    setCfg(0, 0, 3, 1'b0); waitTick(1);
    measHigh(1, 5, 2, "R7", "divisor 5 p1 ratio 1");
    setCfg(0, 3, 0, 1'b0); waitTick(1);
    measHigh(1, 16, 8, "R7", "divisor 2 p1 ratio 8");

    // R8: change the first prescaler code partway through a period
    setCfg(3, 0, 0, 1'b0); waitTick(0); waitTick(0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    p0Code = 2'd0;
    gapToTick(0, gap);
    chk("R8", "p0 period in progress finishes", gap, 7);
    gapToTick(0, gap);
    chk("R8", "p0 new ratio after wrap", gap, 1);

    // R8: change the divider value partway through a period
    setCfg(0, 0, 9, 1'b0); waitTick(1); waitTick(1);
    @(posedge clk); #1;
    nValue = 10'd0;
    gapToTick(1, gap);
    chk("R8", "out1 period in progress finishes", gap, 11);
    gapToTick(1, gap);
    chk("R8", "out1 new divisor after wrap", gap, 2);

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule